// File: doc/BRIEF.md
# Multi-Waveform Audio Oscillator

This block is a phase-accumulator tone source that feeds one channel of an audio codec DAC. On each left-channel sample-ready strobe it produces one new sample and advances its phase by a programmed increment. The sample comes from one of four shapes: sawtooth, square, triangle, or sine. The sine is read from a lookup table that the block fills at elaboration. The table holds either a quarter wave, mirrored by the two top phase bits, or a full wave.

The sample is provided as a signed two's-complement word and also in offset-binary form for the DAC. The right-channel output always carries the code for silence. Between strobes nothing moves, so the system clock can run much faster than the audio rate. The pitch is set by the increment: f_out = f_strobe * inc / 2^PHASE_W.

Top module: `wave_osc`

## Requirements
- R1: A synchronous active-high reset clears the phase, the increment register and the sample to zero. The first strobe after reset outputs the selected waveform's value at phase zero.
- R2: `inc_i` is captured into a register on every clock. On a strobe the phase becomes phase + captured increment, so an increment takes effect at a strobe at least one clock after it is presented.
- R3: Select 0 (sawtooth) outputs the top SAMPLE_W phase bits minus 2^(SAMPLE_W-1). Phase zero gives the most negative code.
- R4: Select 1 (square) outputs +((2^(SAMPLE_W-1)-1) >> SQ_SHIFT) while the phase MSB is 0, and the negated value while it is 1. With the defaults this is ±16383, never rail to rail.
- R5: Select 2 (triangle) folds the sawtooth. Let x be the top SAMPLE_W phase bits, replaced by 2^SAMPLE_W-1-x when the phase MSB is set. The output is 2x - 2^(SAMPLE_W-1).
- R6: Select 3 (sine) outputs round((2^(SAMPLE_W-1)-1) * sin(2π(j+0.5)/2^(LUT_AW+2))). Here j is the top LUT_AW+2 phase bits, and rounding is half away from zero.
- R7: `dac_left_o` equals the sample with its sign bit inverted, which is the sample plus 2^(SAMPLE_W-1) in offset binary.
- R8: `dac_right_o` always equals 2^(SAMPLE_W-1), the offset-binary code of zero.
- R9: When no strobe occurs, the sample and the phase hold; input changes have no effect until the next strobe.
- R10: The phase wraps modulo 2^PHASE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_i | input | PHASE_W | Phase increment per sample |
| wave_sel_i | input | 2 | 0 saw, 1 square, 2 triangle, 3 sine |
| left_rdy_i | input | 1 | Left-channel sample-ready strobe |
| sample_o | output | SAMPLE_W | Current sample, two's complement |
| dac_left_o | output | SAMPLE_W | Current sample, offset binary |
| dac_right_o | output | SAMPLE_W | Right-channel silence code |

## Verification
Each shape is run with a tiny increment, which walks the table and fold points one step at a time. It is also run with a large increment that wraps the phase within a few samples and exposes any carry or wrap fault. Strobes arrive both at a steady audio-like pace and at irregular gaps. This separates an oscillator that moves per strobe from one that moves per clock. The increment and the select are changed between strobes and the design is reset mid-tone. These cases show whether the captured increment timing and the phase-zero restart are right. A cycle-level behavioural model predicts every output on every clock.

// File: rtl/wave_osc.sv
module wave_osc #(
  parameter int PHASE_W    = 24,
  parameter int SAMPLE_W   = 16,
  parameter int LUT_AW     = 8,
  parameter bit FULL_TABLE = 1'b0,
  parameter int SQ_SHIFT   = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PHASE_W-1:0]         inc_i,
  input  logic [1:0]                 wave_sel_i,
  input  logic                       left_rdy_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic [SAMPLE_W-1:0]        dac_left_o,
  output logic [SAMPLE_W-1:0]        dac_right_o
);
  localparam int N      = 1 << LUT_AW;
  localparam int AMP    = (1 << (SAMPLE_W-1)) - 1;
  localparam int SQ_AMP = AMP >>> SQ_SHIFT;
  localparam logic signed [SAMPLE_W-1:0] SQ_POS = SAMPLE_W'(SQ_AMP);
  localparam logic signed [SAMPLE_W-1:0] SQ_NEG = -SQ_POS;

  function automatic int sin_code(input int j);
    real x;
    x = AMP * $sin(2.0 * 3.14159265358979323846 * (j + 0.5) / (4.0 * N));
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  logic [PHASE_W-1:0]         phase_q, inc_q;
  logic signed [SAMPLE_W-1:0] sample_q, saw_w, sq_w, tri_w, sin_w, wave_w;
  logic [SAMPLE_W-1:0]        top_w;
  logic [SAMPLE_W-2:0]        fold_w;

  assign top_w  = phase_q[PHASE_W-1 -: SAMPLE_W];
  assign saw_w  = {~top_w[SAMPLE_W-1], top_w[SAMPLE_W-2:0]};
  assign sq_w   = phase_q[PHASE_W-1] ? SQ_NEG : SQ_POS;
  assign fold_w = top_w[SAMPLE_W-1] ? ~top_w[SAMPLE_W-2:0] : top_w[SAMPLE_W-2:0];
  assign tri_w  = {~fold_w[SAMPLE_W-2], fold_w[SAMPLE_W-3:0], 1'b0};

  generate
    if (FULL_TABLE) begin : g_full
      logic signed [SAMPLE_W-1:0] rom [4*N];
      initial for (int j = 0; j < 4*N; j++) rom[j] = SAMPLE_W'(sin_code(j));
      assign sin_w = rom[phase_q[PHASE_W-1 -: LUT_AW+2]];
    end else begin : g_quarter
      logic [SAMPLE_W-2:0] rom [N];
      logic [1:0]          quad;
      logic [LUT_AW-1:0]   idx, addr;
      logic signed [SAMPLE_W-1:0] mag;
      initial for (int i = 0; i < N; i++) rom[i] = (SAMPLE_W-1)'(sin_code(i));
      assign quad  = phase_q[PHASE_W-1 -: 2];
      assign idx   = phase_q[PHASE_W-3 -: LUT_AW];
      assign addr  = quad[0] ? ~idx : idx;
      assign mag   = {1'b0, rom[addr]};
      assign sin_w = quad[1] ? -mag : mag;
    end
  endgenerate

  always_comb begin
    case (wave_sel_i)
      2'd0:    wave_w = saw_w;
      2'd1:    wave_w = sq_w;
      2'd2:    wave_w = tri_w;
      default: wave_w = sin_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      inc_q    <= '0;
      sample_q <= '0;
    end else begin
      inc_q <= inc_i;
      if (left_rdy_i) begin
        sample_q <= wave_w;
        phase_q  <= phase_q + inc_q;
      end
    end
  end

  assign sample_o    = sample_q;
  assign dac_left_o  = {~sample_q[SAMPLE_W-1], sample_q[SAMPLE_W-2:0]};
  assign dac_right_o = {1'b1, {(SAMPLE_W-1){1'b0}}};
endmodule

// File: rtl/wave_osc_chk.sv
module wave_osc_chk #(
  parameter int SAMPLE_W = 16,
  parameter int SQ_SHIFT = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [1:0]                 wave_sel_i,
  input logic                       left_rdy_i,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input logic [SAMPLE_W-1:0]        dac_left_o,
  input logic [SAMPLE_W-1:0]        dac_right_o
);
  localparam int AMP = (1 << (SAMPLE_W-1)) - 1;
  localparam logic signed [SAMPLE_W-1:0] SQ_P = SAMPLE_W'(AMP >>> SQ_SHIFT);
  localparam logic signed [SAMPLE_W-1:0] LIM  = SAMPLE_W'(AMP);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (sample_o == '0 && dac_left_o[SAMPLE_W-1]));
  // R9
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !left_rdy_i |=> $stable(sample_o));
  // R4
  square_level_chk: assert property (@(posedge clk) disable iff (rst)
    (left_rdy_i && wave_sel_i == 2'd1) |=> (sample_o == SQ_P || sample_o == -SQ_P));
  // R6
  sine_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (left_rdy_i && wave_sel_i == 2'd3) |=> (sample_o <= LIM && sample_o >= -LIM));
  // R8
  right_silent_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(dac_right_o) == 1 && dac_right_o[SAMPLE_W-1]);
endmodule

bind wave_osc wave_osc_chk #(.SAMPLE_W(SAMPLE_W), .SQ_SHIFT(SQ_SHIFT)) chk_i (
  .clk(clk), .rst(rst), .wave_sel_i(wave_sel_i), .left_rdy_i(left_rdy_i),
  .sample_o(sample_o), .dac_left_o(dac_left_o), .dac_right_o(dac_right_o));

// File: tb/wave_osc_tb.sv
module wave_osc_tb_top;
  localparam int P = 24, W = 16, LAW = 8;
  localparam int AMP = (1 << (W-1)) - 1;

  logic clk = 0, rst = 1, rdy = 0;
  logic [P-1:0] inc = '0;
  logic [1:0] sel = '0;
  logic signed [W-1:0] sample;
  logic [W-1:0] dl, dr;

  always #2 clk = ~clk;

  wave_osc dut_i (.clk(clk), .rst(rst), .inc_i(inc), .wave_sel_i(sel), .left_rdy_i(rdy),
                  .sample_o(sample), .dac_left_o(dl), .dac_right_o(dr));

  int checks = 0, errors = 0, cycles = 0;
  longint m_phase = 0, m_inc = 0, m_sample = 0;
  string m_tag = "R1";

  function automatic longint ref_wave(input int s, input longint ph);
    longint x, j;
    real r;
    x = ph >> (P - W);
    case (s)
      0: return x - (1 << (W-1));
      1: return ph[P-1] ? -(AMP >> 1) : (AMP >> 1);
      2: begin
        if (x >= (1 << (W-1))) x = (1 << W) - 1 - x;
        return 2*x - (1 << (W-1));
      end
      default: begin
        j = ph >> (P - LAW - 2);
        r = AMP * $sin(2.0 * 3.14159265358979323846 * (j + 0.5) / (4.0 * (1 << LAW)));
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
      end
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_phase = 0; m_inc = 0; m_sample = 0; m_tag = "R1";
    end else begin
      if (rdy) begin
        m_sample = ref_wave(sel, m_phase);
        m_tag = (m_phase == 0) ? "R1" : (sel == 0) ? "R3" : (sel == 1) ? "R4" : (sel == 2) ? "R5" : "R6";
        m_phase = (m_phase + m_inc) % (64'd1 << P);
      end else m_tag = "R9";
      m_inc = inc;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    chk({m_tag, "/R2/R10 sample"}, sample, m_sample);
    chk("R7 dac_left", dl, (m_sample + (1 << (W-1))) & ((1 << W) - 1));
    chk("R8 dac_right", dr, 1 << (W-1));
  end

  task automatic run(input int n, input int gap, input logic [P-1:0] i, input int s);
    inc = i; sel = 2'(s);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rdy = 1;
      @(negedge clk); rdy = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset sample", sample, 0);
    for (int s = 0; s < 4; s++) begin
      run(1100, 2, 24'h004000, s);   // slow sweep
      run(300, 1, 24'h3A7F13, s);    // fast, wraps
      run(200, (s + 3) % 7, 24'h01F0A5, s); // irregular gaps
    end
    // change increment and select between strobes
    inc = 24'h123456; sel = 2'd3;
    repeat (5) @(negedge clk);
    inc = 24'h000001; sel = 2'd0;
    run(40, 0, 24'h0FFFFF, 2);
    // mid-tone reset, then first strobe gives phase-zero value
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R1 after reset", sample, 0);
    run(30, 3, 24'h080000, 0);
    run(30, 3, 24'h080000, 3);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule